// File: doc/BRIEF.md
# Per-Queue Time-Aware Transmit Gate

This block decides, cycle by cycle, whether each of several egress queues may transmit. Every queue owns a programmable absolute start time, an open length and a closed length. Once a queue is switched on and the local time-of-day has reached its start time, the queue's gate swings open for the open length, shuts for the closed length, and repeats that window indefinitely. A queue that is switched off leaves its gate open, so unscheduled traffic is never blocked.

Open and closed lengths are counted in link byte-times, not clock cycles. A byte-time tick input advances the counters, so one unit is the duration of one byte at the current link speed (8 ns at 1 Gb/s). Software converts a nanosecond interval to units as ns × Mbps / 8000, rounded up. The time-of-day input supplies the two low bits of the seconds count and a 30-bit nanoseconds count.

Each queue runs its own state machine with four states. IDLE: the queue is switched off and the gate is open. WAIT: the queue is armed and the gate is closed until the start time is reached. OPEN: the gate is open while the open counter runs down. SHUT: the gate is closed while the closed counter runs down. The transitions are as follows. Any state goes to IDLE when the queue is switched off. IDLE goes to WAIT when the queue is switched on. WAIT goes to OPEN at the start time, or to SHUT if the open length is zero. OPEN goes to SHUT when its count expires, or reloads and stays in OPEN if the closed length is zero. SHUT goes to OPEN when its count expires, or reloads and stays in SHUT if the open length is zero.

Top module: `tx_time_gate`

## Requirements
- R1: After reset every gate output is 1, the control readback is 0 and every timing register reads 0.
- R2: Registers use word addresses. The start time of queue q is at 0x200+q and holds seconds in bits [31:30] and nanoseconds in bits [29:0]. The open length is at 0x208+q and the closed length at 0x210+q. Both length registers keep only bits [16:0]: the upper bits are dropped on write and read back as 0. Control is at 0x220.
- R3: A control write with bit q set switches queue q on. A control write with bit 16+q set switches it off. One write may affect several queues. If both bits are set for the same queue, off wins. Reading control returns the on/off status in bits [NQ-1:0].
- R4: A queue that is switched off has gate output 1 from the second cycle after the write.
- R5: A queue that is switched on shows a closed gate in the cycle after the control register updates. The gate stays closed until {tod_sec[1:0], tod_ns} is greater than or equal to the start register. The gate then opens in the cycle after the first such sample.
- R6: The gate then stays open for the open length in ticks, is closed for the closed length in ticks, and repeats.
- R7: The counters move only on cycles where byte_tick is 1. Without ticks, the gate holds its current phase.
- R8: An open length of 0 keeps an armed gate closed permanently. A closed length of 0 (with a nonzero open length) keeps it open permanently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 10 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| tod_sec | input | 2 | Low two bits of time-of-day seconds |
| tod_ns | input | 30 | Time-of-day nanoseconds |
| byte_tick | input | 1 | One pulse per link byte-time |
| gate_open | output | NQ | Per-queue transmit gate, 1 = open |

## Verification
The schedule is driven with a start time already in the past, which shows that the gate opens as soon as it is armed. It is also driven with a start time in the future whose seconds field differs from the time-of-day and whose nanoseconds sit one below the start value, which separates a full 32-bit comparison from a nanoseconds-only or strict comparison. Windows of 3/2, 4/4, 0/5 and 7/0 ticks show whether phase lengths, reloads and skipped phases are counted correctly. A stretch with the tick held low shows whether the counters are clocked by the clock or by byte-times.

// File: rtl/ttg_pkg.sv
package ttg_pkg;
    localparam int REG_AW = 10;
    localparam int BANK_W = REG_AW - 3;
    localparam logic [BANK_W-1:0] BANK_START = 7'h40;
    localparam logic [BANK_W-1:0] BANK_ON    = 7'h41;
    localparam logic [BANK_W-1:0] BANK_OFF   = 7'h42;
    localparam logic [BANK_W-1:0] BANK_CTRL  = 7'h44;
    localparam int DIS_BASE = 16;

    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_WAIT = 2'd1,
        GS_OPEN = 2'd2,
        GS_SHUT = 2'd3
    } gate_st_t;
endpackage

// File: rtl/ttg_regfile.sv
module ttg_regfile
    import ttg_pkg::*;
#(
    parameter int NQ   = 4,
    parameter int LENW = 17
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_AW-1:0]        wr_addr,
    input  logic [31:0]              wr_data,
    input  logic [REG_AW-1:0]        rd_addr,
    output logic [31:0]              rd_data,
    output logic [NQ-1:0][31:0]      start_o,
    output logic [NQ-1:0][LENW-1:0]  on_o,
    output logic [NQ-1:0][LENW-1:0]  off_o,
    output logic [NQ-1:0]            en_o
);
    localparam int IW = $clog2(NQ);

    logic [NQ-1:0][31:0]     start_q;
    logic [NQ-1:0][LENW-1:0] on_q;
    logic [NQ-1:0][LENW-1:0] off_q;
    logic [NQ-1:0]           en_q;

    logic [BANK_W-1:0] wr_bank, rd_bank;
    logic [2:0]        wr_idx, rd_idx;
    logic [IW-1:0]     wr_q, rd_q;
    logic              wr_ok, rd_ok, ctrl_wr;

    assign wr_bank = wr_addr[REG_AW-1:3];
    assign wr_idx  = wr_addr[2:0];
    assign wr_q    = wr_idx[IW-1:0];
    assign wr_ok   = int'(wr_idx) < NQ;
    assign rd_bank = rd_addr[REG_AW-1:3];
    assign rd_idx  = rd_addr[2:0];
    assign rd_q    = rd_idx[IW-1:0];
    assign rd_ok   = int'(rd_idx) < NQ;
    assign ctrl_wr = wr_en && (wr_bank == BANK_CTRL) && (wr_idx == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            on_q    <= '0;
            off_q   <= '0;
            en_q    <= '0;
        end else if (wr_en) begin
            unique case (wr_bank)
                BANK_START: if (wr_ok) start_q[wr_q] <= wr_data;
                BANK_ON:    if (wr_ok) on_q[wr_q]    <= wr_data[LENW-1:0];
                BANK_OFF:   if (wr_ok) off_q[wr_q]   <= wr_data[LENW-1:0];
                BANK_CTRL:  if (wr_idx == 3'd0)
                    en_q <= (en_q | wr_data[NQ-1:0]) & ~wr_data[DIS_BASE +: NQ];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_bank)
            BANK_START: if (rd_ok) rd_data = start_q[rd_q];
            BANK_ON:    if (rd_ok) rd_data = 32'(on_q[rd_q]);
            BANK_OFF:   if (rd_ok) rd_data = 32'(off_q[rd_q]);
            BANK_CTRL:  if (rd_idx == 3'd0) rd_data = 32'(en_q);
            default: ;
        endcase
    end

    assign start_o = start_q;
    assign on_o    = on_q;
    assign off_o   = off_q;
    assign en_o    = en_q;

    // R3: a disable bit always leaves the queue switched off
    p_dis_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> ((en_q & $past(wr_data[DIS_BASE +: NQ])) == '0));
endmodule

// File: rtl/ttg_queue_fsm.sv
module ttg_queue_fsm
    import ttg_pkg::*;
#(
    parameter int LENW = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            tick_i,
    input  logic            reached_i,
    input  logic [LENW-1:0] on_len_i,
    input  logic [LENW-1:0] off_len_i,
    output logic            gate_o
);
    localparam logic [LENW-1:0] ONE = LENW'(1);

    gate_st_t        st_q, st_d;
    logic [LENW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!en_i) begin
            st_d  = GS_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                GS_IDLE: st_d = GS_WAIT;
                GS_WAIT: if (reached_i) begin
                    if (on_len_i != '0) begin
                        st_d  = GS_OPEN;
                        cnt_d = on_len_i;
                    end else begin
                        st_d  = GS_SHUT;
                        cnt_d = off_len_i;
                    end
                end
                GS_OPEN: if (tick_i) begin
                    if (cnt_q <= ONE) begin
                        if (off_len_i != '0) begin
                            st_d  = GS_SHUT;
                            cnt_d = off_len_i;
                        end else begin
                            cnt_d = on_len_i;
                        end
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                GS_SHUT: if (tick_i) begin
                    if (cnt_q <= ONE) begin
                        if (on_len_i != '0) begin
                            st_d  = GS_OPEN;
                            cnt_d = on_len_i;
                        end else begin
                            cnt_d = off_len_i;
                        end
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: st_d = GS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= GS_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        unique case (st_q)
            GS_IDLE: gate_o = 1'b1;
            GS_WAIT: gate_o = 1'b0;
            GS_OPEN: gate_o = 1'b1;
            GS_SHUT: gate_o = 1'b0;
            default: gate_o = 1'b1;
        endcase
    end

    p_disabled_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> gate_o);
    p_wait_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q == GS_WAIT && !reached_i) |=> !gate_o);
    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q == GS_OPEN && !tick_i) |=> ($stable(cnt_q) && st_q == GS_OPEN));
    p_skip_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q == GS_OPEN && off_len_i == '0) |=> gate_o);
endmodule

// File: rtl/tx_time_gate.sv
module tx_time_gate
    import ttg_pkg::*;
#(
    parameter int NQ   = 4,
    parameter int LENW = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [1:0]        tod_sec,
    input  logic [29:0]       tod_ns,
    input  logic              byte_tick,
    output logic [NQ-1:0]     gate_open
);
    logic [NQ-1:0][31:0]     start_w;
    logic [NQ-1:0][LENW-1:0] on_w;
    logic [NQ-1:0][LENW-1:0] off_w;
    logic [NQ-1:0]           en_w;
    logic [31:0]             now_w;

    assign now_w = {tod_sec, tod_ns};

    ttg_regfile #(.NQ(NQ), .LENW(LENW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .start_o (start_w),
        .on_o    (on_w),
        .off_o   (off_w),
        .en_o    (en_w)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        logic reached;
        assign reached = now_w >= start_w[q];

        ttg_queue_fsm #(.LENW(LENW)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (en_w[q]),
            .tick_i    (byte_tick),
            .reached_i (reached),
            .on_len_i  (on_w[q]),
            .off_len_i (off_w[q]),
            .gate_o    (gate_open[q])
        );
    end
endmodule

// File: tb/test_tx_time_gate.sv
module test_tx_time_gate;
    localparam int NQ = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [9:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  tod_sec = '0;
    logic [29:0] tod_ns = '0;
    logic        byte_tick = 1'b1;
    logic [NQ-1:0] gate_open;

    int n_total = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    at;
        int    q;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tx_time_gate #(.NQ(NQ)) i_tx_time_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .byte_tick(byte_tick),
        .gate_open(gate_open)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h cycle=%0d", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_gate(input int k, input int q, input logic v, input string tag);
        exp_t e;
        e.at = cyc + k; e.q = q; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin : monitor
        exp_t e;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            check(e.tag, 32'(gate_open[e.q]), 32'(e.val));
        end
    end

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [9:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_total++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 gates", 32'(gate_open), 32'hF);
        rd_check(10'h220, 32'h0, "R1 ctrl");
        rd_check(10'h202, 32'h0, "R1 start2");
        rd_check(10'h211, 32'h0, "R1 off1");

        // R6: queue 0, start in the past, open 3 / closed 2
        wr(10'h208, 32'd3);
        wr(10'h210, 32'd2);
        wr(10'h220, 32'h1);
        expect_gate(1, 0, 1'b0, "R5 armed closed");
        for (int k = 2; k <= 21; k++) begin
            expect_gate(k, 0, ((k - 2) % 5) < 3, "R6 window 3/2");
            expect_gate(k, 1, 1'b1, "R4 other queue open");
        end
        drain();
        wr(10'h220, 32'h0001_0000);
        expect_gate(1, 0, 1'b1, "R4 off reopens");
        expect_gate(2, 0, 1'b1, "R4 off reopens");
        drain();

        // R5: future start time on queue 1
        tod_sec = 2'd0; tod_ns = 30'd500;
        wr(10'h201, 32'h4000_0064);
        wr(10'h209, 32'd4);
        wr(10'h211, 32'd4);
        wr(10'h220, 32'h2);
        for (int k = 1; k <= 10; k++) expect_gate(k, 1, 1'b0, "R5 before start");
        drain();
        tod_sec = 2'd1; tod_ns = 30'd99;
        for (int k = 1; k <= 3; k++) expect_gate(k, 1, 1'b0, "R5 one below start");
        drain();
        tod_ns = 30'd100;
        for (int k = 1; k <= 12; k++) expect_gate(k, 1, ((k - 1) % 8) < 4, "R6 window 4/4");
        drain();
        wr(10'h220, 32'h0002_0002);
        rd_check(10'h220, 32'h0, "R3 disable wins");
        expect_gate(1, 1, 1'b1, "R4 after disable");
        drain();

        // R8: zero open on q2, zero closed on q3, enabled together
        wr(10'h212, 32'd5);
        wr(10'h20B, 32'd7);
        wr(10'h220, 32'hC);
        rd_check(10'h220, 32'hC, "R3 multi enable");
        expect_gate(1, 2, 1'b0, "R5 armed q2");
        expect_gate(1, 3, 1'b0, "R5 armed q3");
        for (int k = 2; k <= 20; k++) begin
            expect_gate(k, 2, 1'b0, "R8 zero open");
            expect_gate(k, 3, 1'b1, "R8 zero closed");
        end
        drain();
        wr(10'h220, 32'h000C_0000);
        expect_gate(1, 2, 1'b1, "R3 multi disable");
        expect_gate(1, 3, 1'b1, "R3 multi disable");
        drain();

        // R7 and R2: ticks held low, upper length bits dropped
        byte_tick = 1'b0;
        wr(10'h208, 32'hFFFE_0002);
        wr(10'h210, 32'd2);
        rd_check(10'h208, 32'h2, "R2 length upper bits");
        rd_check(10'h201, 32'h4000_0064, "R2 start readback");
        wr(10'h220, 32'h1);
        expect_gate(1, 0, 1'b0, "R5 armed q0");
        for (int k = 2; k <= 15; k++) expect_gate(k, 0, 1'b1, "R7 no tick holds");
        drain();
        byte_tick = 1'b1;
        expect_gate(1, 0, 1'b1, "R7 tick resumes");
        expect_gate(2, 0, 1'b0, "R7 tick resumes");
        expect_gate(3, 0, 1'b0, "R7 tick resumes");
        expect_gate(4, 0, 1'b1, "R7 tick resumes");
        expect_gate(5, 0, 1'b1, "R7 tick resumes");
        expect_gate(6, 0, 1'b0, "R7 tick resumes");
        drain();

        // R2 / R4: disable and clear back to unscheduled
        wr(10'h220, 32'h0001_0000);
        wr(10'h201, 32'h0);
        wr(10'h209, 32'h0);
        wr(10'h211, 32'h0);
        rd_check(10'h201, 32'h0, "R2 cleared start");
        rd_check(10'h209, 32'h0, "R2 cleared on");
        rd_check(10'h211, 32'h0, "R2 cleared off");
        rd_check(10'h220, 32'h0, "R3 all off");
        @(negedge clk);
        check("R4 all open", 32'(gate_open), 32'hF);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule